// File: doc/BRIEF.md
# Attribute-Typed Control Register Bank

This block is a small word-addressed register bank. Every bit of every register carries two attributes. The read attribute says what a host read of that bit returns: zero, the stored bit, or a live hardware value. The write attribute says what a host write does to it: nothing, a load, or a clear where a 1 is written.

From these two attributes the bank builds four kinds of bit:

- **read-only status:** returns the live hardware value; writes do nothing.
- **write-only command:** loads on write; reads return zero.
- **read/write:** loads on write and reads back the stored value.
- **write-one-to-clear event:** reads back the stored value, and a host write of 1 clears it.

Combining a read attribute of "hardware value" with a write attribute of "load" puts a read-only register and a write-only register at the same address.

Hardware logic drives the live read-only values and pulses set requests into the clear-on-one bits. It observes every stored bit on a flat output bus. Registers that contain write-only bits emit a one-cycle strobe each time they are written. The attribute map is computed by a package function, and the reset value of every stored bit comes from a parameter.

The example map has eight word registers:

| Index | Contents |
|---|---|
| 0 | read/write |
| 1 | clear-on-one events |
| 2 | read-only |
| 3 | aliased pair |
| 4 | write-only |
| 5 | mixed per byte: byte 0 read/write, byte 1 clear-on-one, byte 2 read-only, byte 3 write-only |
| 6, 7 | unmapped |

Top module: `regbank_top`

## Requirements
- R1: In every reset cycle, each stored bit takes its value from RST_VAL, and `host_rvalid` and `wo_stb` are 0. The defaults are 32'hA5A50001 for register 0 and 32'h5A000F3C for register 5; all other registers default to 0.
- R2: Read-only bits (all of register 2) return `hw_ro_in[r*32 +: 32]` on a read. Writes to them change no state, and their lanes of `reg_q` read 0.
- R3: Read/write bits (register 0) load the written data and return the stored value on a read.
- R4: Clear-on-one bits (register 1) are cleared by a host write of 1. A written 0 leaves the bit unchanged, and reads return the stored value.
- R5: A high `hw_set_in` bit sets its clear-on-one bit on the next edge. If a host clear hits that bit in the same cycle, the bit still ends at 1. `hw_set_in` has no effect on bits of any other kind.
- R6: At the aliased address (register 3), reads return `hw_ro_in[3*32 +: 32]`, while writes load the write-only store shown on `reg_q[3*32 +: 32]`.
- R7: Write-only bits (register 4) read as 0, and a read changes no state. `wo_stb[r]` pulses one cycle after any write with a nonzero byte enable to registers 3, 4 or 5.
- R8: Byte enable bit k guards data bits 8k+7..8k. Only enabled bytes of load and clear-on-one bits are affected.
- R9: Register 5 applies its attributes per byte. A read returns {8'h0, hw byte 2, stored byte 1, stored byte 0}, and `reg_q` shows {stored byte 3, 8'h0, stored byte 1, stored byte 0}.
- R10: Unmapped addresses (6 and 7) read as zero and ignore writes.
- R11: `host_rdata` and `host_rvalid` are registered. They reflect a read one cycle after `host_rd`, and `host_rdata` is 0 in cycles with no read. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | AW (3) | Word address for read and write |
| host_wr | input | 1 | Write request |
| host_rd | input | 1 | Read request |
| host_wdata | input | DW (32) | Write data |
| host_be | input | DW/8 (4) | Write byte enables |
| host_rdata | output | DW (32) | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| hw_ro_in | input | NREG*DW (256) | Live read-only values, register r in lane r |
| hw_set_in | input | NREG*DW (256) | Set pulses for clear-on-one bits, register r in lane r |
| reg_q | output | NREG*DW (256) | Stored bits per register, zero where nothing is stored |
| wo_stb | output | NREG (8) | Write strobe per register that holds write-only bits |

## Verification
The bench aims at the cycle where a hardware set and a host clear hit the same event bit. A design that lets the clear win would drop the event and leave the bit at 0. It also writes to the read-only, unmapped and aliased addresses. A design that decoded the alias from one side only would return the write-only store on a read, or let the write corrupt nothing visible while the strobe stays dead. Partial byte enables and the mixed register expose a design that treats attributes per register rather than per bit, for example one that clears read/write bits on a 1 or stores into the read-only byte. Same-cycle read and write catches forwarding of the new value into the read path.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [1:0] {
        RD_ZERO  = 2'd0,
        RD_STORE = 2'd1,
        RD_HW    = 2'd2
    } rd_src_e;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_LOAD = 2'd1,
        WR_CLR1 = 2'd2
    } wr_kind_e;

    typedef struct packed {
        rd_src_e  rd;
        wr_kind_e wr;
    } bit_attr_t;

    localparam bit_attr_t ATT_RO    = '{rd: RD_HW,    wr: WR_NONE};
    localparam bit_attr_t ATT_WO    = '{rd: RD_ZERO,  wr: WR_LOAD};
    localparam bit_attr_t ATT_RW    = '{rd: RD_STORE, wr: WR_LOAD};
    localparam bit_attr_t ATT_W1C   = '{rd: RD_STORE, wr: WR_CLR1};
    localparam bit_attr_t ATT_ALIAS = '{rd: RD_HW,    wr: WR_LOAD};
    localparam bit_attr_t ATT_NONE  = '{rd: RD_ZERO,  wr: WR_NONE};

    // Example map: attribute of bit b in register r.
    function automatic bit_attr_t attr_of(int r, int b);
        bit_attr_t a;
        case (r)
            0: a = ATT_RW;
            1: a = ATT_W1C;
            2: a = ATT_RO;
            3: a = ATT_ALIAS;
            4: a = ATT_WO;
            5: begin
                case (b / 8)
                    0:       a = ATT_RW;
                    1:       a = ATT_W1C;
                    2:       a = ATT_RO;
                    default: a = ATT_WO;
                endcase
            end
            default: a = ATT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG),
    localparam int BW  = DW / 8
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [BW-1:0]   be,
    output logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] rd_sel,
    output logic [DW-1:0]   bmask
);

    for (genvar g = 0; g < BW; g++) begin : g_byte
        assign bmask[g*8 +: 8] = {8{be[g]}};
    end

    for (genvar r = 0; r < NREG; r++) begin : g_hit
        assign wr_hit[r] = wr_en && (addr == AW'(r));
        assign rd_sel[r] = rd_en && (addr == AW'(r));
    end

endmodule

// File: rtl/regbank_reg.sv
module regbank_reg
    import regbank_pkg::*;
#(
    parameter int            DW  = 32,
    parameter int            IDX = 0,
    parameter logic [DW-1:0] RST = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] bmask,
    input  logic [DW-1:0] hw_set,
    input  logic [DW-1:0] hw_ro,
    output logic [DW-1:0] q_out,
    output logic [DW-1:0] rd_val,
    output logic          wo_stb
);

    logic [DW-1:0] load_m, clr_m, rdst_m, rdhw_m, store_m, wo_m;
    logic [DW-1:0] q, q_nxt, wmask;
    logic          has_wo;

    for (genvar b = 0; b < DW; b++) begin : g_attr
        localparam bit_attr_t A = attr_of(IDX, b);
        assign load_m[b] = (A.wr == WR_LOAD);
        assign clr_m[b]  = (A.wr == WR_CLR1);
        assign rdst_m[b] = (A.rd == RD_STORE);
        assign rdhw_m[b] = (A.rd == RD_HW);
    end

    assign store_m = load_m | clr_m;
    assign wo_m    = load_m & ~rdst_m;
    assign has_wo  = |wo_m;
    assign wmask   = wr_hit ? bmask : '0;

    always_comb begin
        q_nxt = (q & ~(load_m & wmask)) | (wr_data & load_m & wmask);
        q_nxt = q_nxt & ~(clr_m & wmask & wr_data);
        q_nxt = q_nxt | (clr_m & hw_set);
        q_nxt = q_nxt & store_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= RST & store_m;
            wo_stb <= 1'b0;
        end else begin
            q      <= q_nxt;
            wo_stb <= has_wo && (|wmask);
        end
    end

    assign q_out  = q;
    assign rd_val = (q & rdst_m) | (hw_ro & rdhw_m);

    // R5: a hardware set always lands, even against a same-cycle clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((q & clr_m & $past(hw_set)) == ($past(hw_set) & clr_m)));

    // R4: a written 1 with no concurrent set clears the bit
    a_r4_w1c_clear: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_hit) |=>
            ((q & $past(clr_m & bmask & wr_data & ~hw_set)) == '0));

    // R3: load bits hold when the register is not written
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && !wr_hit) |=> ((q & load_m) == $past(q & load_m)));

    // R7: a strobe only follows a write to this register
    a_r7_stb_cause: assert property (@(posedge clk) disable iff (rst)
        wo_stb |-> $past(wr_hit));

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
    parameter int NREG = 8,
    parameter int DW   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [NREG-1:0]    rd_sel,
    input  logic [NREG*DW-1:0] rd_vals,
    output logic [DW-1:0]      rdata,
    output logic               rvalid
);

    logic [DW-1:0] mux;

    always_comb begin
        mux = '0;
        for (int r = 0; r < NREG; r++) begin
            if (rd_sel[r]) mux = mux | rd_vals[r*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rdata  <= rd_en ? mux : '0;
            rvalid <= rd_en;
        end
    end

    // R11: valid follows a read by exactly one cycle
    a_r11_valid: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rvalid == $past(rd_en)));

    // R10: at most one register is selected for a read
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_sel));

    // R11: no data is presented without a read
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));

endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter logic [NREG*DW-1:0] RST_VAL = {
        32'h0000_0000, 32'h0000_0000, 32'h5A00_0F3C, 32'h0000_0000,
        32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_0001},
    localparam int AW = $clog2(NREG),
    localparam int BW = DW / 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DW-1:0]      host_wdata,
    input  logic [BW-1:0]      host_be,
    output logic [DW-1:0]      host_rdata,
    output logic               host_rvalid,
    input  logic [NREG*DW-1:0] hw_ro_in,
    input  logic [NREG*DW-1:0] hw_set_in,
    output logic [NREG*DW-1:0] reg_q,
    output logic [NREG-1:0]    wo_stb
);

    logic [NREG-1:0]    wr_hit, rd_sel;
    logic [DW-1:0]      bmask;
    logic [NREG*DW-1:0] rd_vals;

    regbank_decode #(.NREG(NREG), .DW(DW)) u_dec (
        .addr   (host_addr),
        .wr_en  (host_wr),
        .rd_en  (host_rd),
        .be     (host_be),
        .wr_hit (wr_hit),
        .rd_sel (rd_sel),
        .bmask  (bmask)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        regbank_reg #(
            .DW  (DW),
            .IDX (r),
            .RST (RST_VAL[r*DW +: DW])
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_hit[r]),
            .wr_data (host_wdata),
            .bmask   (bmask),
            .hw_set  (hw_set_in[r*DW +: DW]),
            .hw_ro   (hw_ro_in[r*DW +: DW]),
            .q_out   (reg_q[r*DW +: DW]),
            .rd_val  (rd_vals[r*DW +: DW]),
            .wo_stb  (wo_stb[r])
        );
    end

    regbank_rdmux #(.NREG(NREG), .DW(DW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (host_rd),
        .rd_sel  (rd_sel),
        .rd_vals (rd_vals),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

endmodule

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   addr = '0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [31:0]  wdata = '0;
    logic [3:0]   be = '0;
    logic [31:0]  rdata;
    logic         rvalid;
    logic [255:0] hw_ro = '0, hw_set = '0;
    logic [255:0] reg_q;
    logic [7:0]   stb;

    int nchk = 0, nerr = 0;
    logic mon_on = 1'b0;

    always #10 clk = ~clk;

    regbank_top dut (
        .clk(clk), .rst(rst), .host_addr(addr), .host_wr(wr), .host_rd(rd),
        .host_wdata(wdata), .host_be(be), .host_rdata(rdata),
        .host_rvalid(rvalid), .hw_ro_in(hw_ro), .hw_set_in(hw_set),
        .reg_q(reg_q), .wo_stb(stb)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] s [8];
    logic [31:0] e_rd;
    logic        e_valid;
    logic [7:0]  e_stb;

    function automatic string tag_of(int r);
        case (r)
            0: return "R3";
            1: return "R4";
            2: return "R2";
            3: return "R6";
            4: return "R7";
            5: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] m_read(int a);
        case (a)
            0: return s[0];
            1: return s[1];
            2: return hw_ro[64 +: 32];
            3: return hw_ro[96 +: 32];
            5: return (s[5] & 32'h0000_FFFF) | (hw_ro[160 +: 32] & 32'h00FF_0000);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_q(int r);
        case (r)
            0, 1, 3, 4: return s[r];
            5: return s[5] & 32'hFF00_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        for (int r = 0; r < 8; r++) s[r] = 32'h0;
        s[0] = 32'hA5A5_0001;
        s[5] = 32'h5A00_0F3C;
    endtask

    always @(posedge clk) begin
        logic [31:0] bm;
        logic [31:0] lm;
        if (rst) begin
            m_reset();
            e_rd = '0; e_valid = 1'b0; e_stb = '0;
        end else begin
            e_rd    = rd ? m_read(int'(addr)) : 32'h0;
            e_valid = rd;
            e_stb   = '0;
            bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            if (wr) begin
                case (int'(addr))
                    0: s[0] = (s[0] & ~bm) | (wdata & bm);
                    1: s[1] = s[1] & ~(wdata & bm);
                    3, 4: s[addr] = (s[addr] & ~bm) | (wdata & bm);
                    5: begin
                        lm = bm & 32'hFF00_00FF;
                        s[5] = (s[5] & ~lm) | (wdata & lm);
                        s[5] = s[5] & ~(wdata & bm & 32'h0000_FF00);
                    end
                    default: ;
                endcase
                if (be != 4'h0 && addr >= 3 && addr <= 5) e_stb[addr] = 1'b1;
            end
            s[1] = s[1] | hw_set[32 +: 32];
            s[5] = s[5] | (hw_set[160 +: 32] & 32'h0000_FF00);
        end
        #5;
        if (mon_on) begin
            for (int r = 0; r < 8; r++) chk(tag_of(r), reg_q[r*32 +: 32], m_q(r));
            chk("R11", {31'h0, rvalid}, {31'h0, e_valid});
            chk("R7", {24'h0, stb}, {24'h0, e_stb});
            if (e_valid) chk(tag_of(int'(addr_d)), rdata, e_rd);
            else chk("R11", rdata, 32'h0);
        end
    end

    // address of the read being returned this cycle
    logic [2:0] addr_d;
    always @(posedge clk) addr_d <= addr;

    task automatic op(logic w, logic r, logic [2:0] a, logic [31:0] d, logic [3:0] b);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; be = b;
        hw_set = '0;
    endtask

    task automatic idle();
        op(1'b0, 1'b0, 3'd0, 32'h0, 4'h0);
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        hw_ro[64 +: 32]  = 32'h1234_5678;
        hw_ro[96 +: 32]  = 32'hCAFE_0003;
        hw_ro[160 +: 32] = 32'h00AB_0000;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", reg_q[0 +: 32], 32'hA5A5_0001);
        chk("R1", reg_q[160 +: 32], 32'h5A00_0F3C);
        chk("R1", {31'h0, rvalid}, 32'h0);
        rst = 1'b0;

        op(1, 0, 3'd0, 32'hDEAD_BEEF, 4'hF);     // R3
        op(0, 1, 3'd0, 32'h0, 4'h0);
        op(1, 0, 3'd0, 32'h1122_3344, 4'h2);     // R8
        op(0, 1, 3'd0, 32'h0, 4'h0);
        @(posedge clk); #6;
        chk("R8", reg_q[0 +: 32], 32'hDEAD_33EF);

        op(0, 0, 3'd1, 32'h0, 4'h0); hw_set[32 +: 32] = 32'h0000_00F0;
        op(0, 1, 3'd1, 32'h0, 4'h0);             // R4
        op(1, 0, 3'd1, 32'h0000_0030, 4'hF);
        op(1, 1, 3'd1, 32'h0000_0000, 4'hF);
        op(1, 0, 3'd1, 32'h0000_0080, 4'hF);     // R5: clear and set together
        hw_set[32 +: 32] = 32'h0000_0080;
        idle();
        @(posedge clk); #6;
        chk("R5", {31'h0, reg_q[39]}, 32'h1);
        op(1, 0, 3'd0, 32'h0000_FFFF, 4'hF); hw_set[0 +: 32] = 32'hFFFF_0000;
        op(0, 1, 3'd0, 32'h0, 4'h0);             // R5: set ignored on R/W

        op(1, 0, 3'd2, 32'hFFFF_FFFF, 4'hF);     // R2
        op(0, 1, 3'd2, 32'h0, 4'h0);
        op(1, 0, 3'd3, 32'h0000_0055, 4'hF);     // R6
        op(0, 1, 3'd3, 32'h0, 4'h0);
        op(1, 0, 3'd4, 32'h8765_4321, 4'hF);     // R7
        op(0, 1, 3'd4, 32'h0, 4'h0);
        op(1, 0, 3'd4, 32'hFFFF_FFFF, 4'h0);     // R7/R8: no enables, no strobe
        op(1, 0, 3'd5, 32'hFFFF_FFFF, 4'hF);     // R9
        op(0, 1, 3'd5, 32'h0, 4'h0);
        op(1, 0, 3'd5, 32'h0000_0000, 4'h1);
        op(0, 1, 3'd5, 32'h0, 4'h0); hw_set[160 +: 32] = 32'h0101_0101;
        op(1, 0, 3'd6, 32'hFFFF_FFFF, 4'hF);     // R10
        op(0, 1, 3'd6, 32'h0, 4'h0);
        op(0, 1, 3'd7, 32'h0, 4'h0);
        op(1, 1, 3'd0, 32'h0BAD_F00D, 4'hF);     // R11: old value returned
        op(0, 1, 3'd0, 32'h0, 4'h0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            op(rv[0], rv[1], rv[4:2], $urandom, rv[8:5]);
            if (rv[12:9] == 4'h0) hw_set = {$urandom, $urandom, $urandom, $urandom,
                                            $urandom, $urandom, $urandom, $urandom};
            if (rv[15:13] == 3'h0) hw_ro = {$urandom, $urandom, $urandom, $urandom,
                                            $urandom, $urandom, $urandom, $urandom};
        end
        idle();
        idle();
        @(posedge clk); #8;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule